// File: doc/BRIEF.md
# Demand and Patrol Memory Scrub Engine

This engine sits next to a memory controller and repairs lines that hold a correctable error. Each line is a 256-bit payload with a 32-bit check word stored beside it. A scrub reads one line, computes the check word again from the payload it read, and compares it with the stored one. A correctable mismatch causes a write-back of the repaired payload and a fresh check word as one write. A clean line ends the scrub with no write. An uncorrectable line raises a sticky error flag and records its address. Nothing is written to that line.

Scrubs come from two sources. Demand scrubs come from the read path, when a normal access has seen a correctable error. Patrol scrubs are started by a free-running interval timer and step through every line address in order. Set the interval so that the whole memory is covered about once a day, and never tighter than the slowest rate the controller can absorb. Only one scrub is in progress at any time. A demand goes ahead of a patrol that is pending. A patrol that comes due while the engine is busy is kept until the engine can run it.

Top module: `scrub_engine`

## Requirements
- R1: The check word is laid out as follows. Bits [8:0] hold the XOR of (i+1) over every payload bit i that is 1. Bit 9 holds the even parity of the payload. Bits [31:10] are zero.
- R2: The syndrome S is the recomputed check word XOR the stored one. If S is zero the line is clean. If S[31:10] is zero, S[9] is one and S[8:0] is in 1..256, payload bit S[8:0]-1 is in error. If S has exactly one bit set, the check word is in error. Every other S is uncorrectable.
- R3: A correctable line is written back to the same address in one write. The write carries the repaired payload and a check word recomputed from it. The status is 2'b01.
- R4: A clean line produces no write and status 2'b00.
- R5: An uncorrectable line produces no write and status 2'b10. It sets err_flag, which stays set until reset, and it loads err_addr with that line's address.
- R6: Only one scrub runs at a time. dmd_ack is a one-cycle pulse, given only when a demand scrub starts from idle. busy is high from the start of a scrub until its done cycle.
- R7: The patrol timer runs freely from reset. When nothing else is running, successive patrol scrubs start exactly PATROL_INTERVAL cycles apart.
- R8: A demand request wins over a pending patrol. A patrol that comes due during demand scrubs is kept and starts as soon as the engine is free of demands. It does not wait for another interval.
- R9: Patrol addresses go 0, 1, ..., NUM_LINES-1 and then back to 0, moving on one line per patrol scrub.
- R10: A memory request keeps its address, write enable and data stable until mem_gnt is seen. Each access completes on mem_rsp, and read data is taken in that cycle.
- R11: While reset is held and just after it, busy, mem_req, dmd_ack, scrub_done and err_flag are all low.
- R12: Each scrub ends with one scrub_done pulse, with done_patrol giving its source (1 means patrol). busy is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dmd_req | input | 1 | Demand scrub request, held until dmd_ack |
| dmd_addr | input | ADDR_W | Line address of the demand scrub |
| dmd_ack | output | 1 | Pulse when the demand scrub starts |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write-back, 0 for a read |
| mem_addr | output | ADDR_W | Line address of the access |
| mem_wdata | output | 8*PAY_BYTES | Repaired payload |
| mem_wcheck | output | 8*CHK_BYTES | Recomputed check word |
| mem_gnt | input | 1 | Request accepted |
| mem_rsp | input | 1 | Access complete (read data valid) |
| mem_rdata | input | 8*PAY_BYTES | Payload read back |
| mem_rcheck | input | 8*CHK_BYTES | Stored check word read back |
| busy | output | 1 | A scrub is in progress |
| scrub_done | output | 1 | One-cycle end-of-scrub pulse |
| done_patrol | output | 1 | Source of the finishing scrub |
| done_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| err_flag | output | 1 | Sticky uncorrectable flag |
| err_addr | output | ADDR_W | Address of the last uncorrectable line |

## Verification
Several rules are checked on every cycle:
- a pending request stays stable until it is granted;
- a write happens only for a line classed as corrected;
- the error flag stays set and is set by an uncorrectable result;
- the acknowledge is a single pulse, and busy drops only after a done pulse;
- the patrol address stays in range and changes only when a patrol completes.

Other behaviour can only be shown by the bench's scenarios:
- every single payload-bit and check-bit fault is repaired in the memory model;
- double faults are left in place;
- patrol addresses wrap and patrol starts are spaced exactly one interval apart;
- a patrol held back by a long run of demands starts at once when the run ends.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [1:0] {
    RES_CLEAN  = 2'b00,
    RES_FIXED  = 2'b01,
    RES_UNCORR = 2'b10
  } scrub_res_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RREQ, S_RWAIT, S_CHECK, S_WREQ, S_WWAIT, S_DONE
  } scrub_state_e;
endpackage

// File: rtl/scrub_code.sv
module scrub_code
  import scrub_pkg::*;
#(
  parameter int PAY_W = 256,
  parameter int CHK_W = 32
) (
  input  logic [PAY_W-1:0] data,
  input  logic [CHK_W-1:0] chk_in,
  output scrub_res_e       cls,
  output logic [PAY_W-1:0] fix_data,
  output logic [CHK_W-1:0] fix_chk
);
  localparam int POS_W = $clog2(PAY_W + 1);
  localparam logic [POS_W-1:0] MAXPOS = POS_W'(PAY_W);

  logic [POS_W-1:0] pos;
  logic             par;
  logic [CHK_W-1:0] calc, syn;
  logic [POS_W-1:0] syn_pos;
  logic             data_fix, chk_fix, upper_zero;

  // positional XOR of (index+1) over set bits, plus payload parity
  always_comb begin
    pos = '0;
    par = 1'b0;
    for (int i = 0; i < PAY_W; i++) begin
      if (data[i]) begin
        pos = pos ^ POS_W'(i + 1);
        par = ~par;
      end
    end
  end

  always_comb begin
    calc = '0;
    calc[POS_W-1:0] = pos;
    calc[POS_W]     = par;
  end

  assign syn        = calc ^ chk_in;
  assign syn_pos    = syn[POS_W-1:0];
  assign upper_zero = (syn[CHK_W-1:POS_W+1] == '0);
  assign data_fix   = upper_zero && syn[POS_W] && (syn_pos != '0) && (syn_pos <= MAXPOS);
  assign chk_fix    = $onehot(syn);

  always_comb begin
    for (int i = 0; i < PAY_W; i++) begin
      fix_data[i] = data[i] ^ (data_fix && (syn_pos == POS_W'(i + 1)));
    end
  end

  // flipping payload bit k toggles parity and XORs (k+1) into the position field
  always_comb begin
    fix_chk = calc;
    if (data_fix) begin
      fix_chk[POS_W-1:0] = pos ^ syn_pos;
      fix_chk[POS_W]     = ~par;
    end
  end

  always_comb begin
    if (syn == '0)               cls = RES_CLEAN;
    else if (data_fix || chk_fix) cls = RES_FIXED;
    else                          cls = RES_UNCORR;
  end
endmodule

// File: rtl/scrub_patrol.sv
module scrub_patrol #(
  parameter int ADDR_W    = 20,
  parameter int NUM_LINES = 1 << 20,
  parameter int INTERVAL  = 32_800_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              adv,
  output logic              pend,
  output logic [ADDR_W-1:0] addr
);
  localparam int CNT_W = $clog2(INTERVAL + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(INTERVAL - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(NUM_LINES - 1);

  logic [CNT_W-1:0] cnt;
  logic             due;

  assign due = (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (due) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (due)  pend <= 1'b1;
    else if (take) pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) addr <= '0;
    else if (adv) addr <= (addr == ADDR_LAST) ? '0 : addr + 1'b1;
  end

  // R9
  addr_range_chk: assert property (@(posedge clk) disable iff (rst) addr <= ADDR_LAST);
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(addr));
  // R8
  pend_keep_chk: assert property (@(posedge clk) disable iff (rst) pend && !take |=> pend);
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int PAY_W  = 256,
  parameter int CHK_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dmd_req,
  input  logic [ADDR_W-1:0] dmd_addr,
  output logic              dmd_ack,
  input  logic              patrol_pend,
  input  logic [ADDR_W-1:0] patrol_addr,
  output logic              patrol_take,
  output logic              patrol_adv,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PAY_W-1:0]  mem_wdata,
  output logic [CHK_W-1:0]  mem_wcheck,
  input  logic              mem_gnt,
  input  logic              mem_rsp,
  input  logic [PAY_W-1:0]  mem_rdata,
  input  logic [CHK_W-1:0]  mem_rcheck,
  output logic [PAY_W-1:0]  rd_data,
  output logic [CHK_W-1:0]  rd_chk,
  input  scrub_res_e        cls,
  input  logic [PAY_W-1:0]  fix_data,
  input  logic [CHK_W-1:0]  fix_chk,
  output logic              busy,
  output logic              scrub_done,
  output logic              done_patrol,
  output scrub_res_e        done_status,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr
);
  scrub_state_e      state;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_patrol;
  scrub_res_e        res;
  logic [PAY_W-1:0]  wr_data;
  logic [CHK_W-1:0]  wr_chk;

  assign patrol_take = (state == S_IDLE) && !dmd_req && patrol_pend;
  assign patrol_adv  = (state == S_DONE) && cur_patrol;
  assign mem_req     = (state == S_RREQ) || (state == S_WREQ);
  assign mem_we      = (state == S_WREQ);
  assign mem_addr    = cur_addr;
  assign mem_wdata   = wr_data;
  assign mem_wcheck  = wr_chk;
  assign busy        = (state != S_IDLE);
  assign scrub_done  = (state == S_DONE);
  assign done_patrol = cur_patrol;
  assign done_status = res;

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      dmd_ack    <= 1'b0;
      cur_patrol <= 1'b0;
      cur_addr   <= '0;
      res        <= RES_CLEAN;
      err_flag   <= 1'b0;
      err_addr   <= '0;
    end else begin
      dmd_ack <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (dmd_req) begin
            cur_addr   <= dmd_addr;
            cur_patrol <= 1'b0;
            dmd_ack    <= 1'b1;
            state      <= S_RREQ;
          end else if (patrol_pend) begin
            cur_addr   <= patrol_addr;
            cur_patrol <= 1'b1;
            state      <= S_RREQ;
          end
        end
        S_RREQ:  if (mem_gnt) state <= S_RWAIT;
        S_RWAIT: if (mem_rsp) state <= S_CHECK;
        S_CHECK: begin
          res <= cls;
          if (cls == RES_FIXED) begin
            state <= S_WREQ;
          end else begin
            state <= S_DONE;
            if (cls == RES_UNCORR) begin
              err_flag <= 1'b1;
              err_addr <= cur_addr;
            end
          end
        end
        S_WREQ:  if (mem_gnt) state <= S_WWAIT;
        S_WWAIT: if (mem_rsp) state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // data path registers (no reset)
  always_ff @(posedge clk) begin
    if (state == S_RWAIT && mem_rsp) begin
      rd_data <= mem_rdata;
      rd_chk  <= mem_rcheck;
    end
    if (state == S_CHECK) begin
      wr_data <= fix_data;
      wr_chk  <= fix_chk;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R3
  write_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> done_status == RES_FIXED);
  // R5
  uncorr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    scrub_done && done_status == RES_UNCORR |-> err_flag);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err_flag |=> err_flag);
  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) dmd_ack |=> !dmd_ack);
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> $past(scrub_done));
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) scrub_done |=> !busy);
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
  import scrub_pkg::*;
#(
  parameter int ADDR_W          = 20,
  parameter int NUM_LINES       = 1 << 20,
  parameter int PATROL_INTERVAL = 32_800_000,
  parameter int PAY_BYTES       = 32,
  parameter int CHK_BYTES       = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dmd_req,
  input  logic [ADDR_W-1:0]      dmd_addr,
  output logic                   dmd_ack,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [8*PAY_BYTES-1:0] mem_wdata,
  output logic [8*CHK_BYTES-1:0] mem_wcheck,
  input  logic                   mem_gnt,
  input  logic                   mem_rsp,
  input  logic [8*PAY_BYTES-1:0] mem_rdata,
  input  logic [8*CHK_BYTES-1:0] mem_rcheck,
  output logic                   busy,
  output logic                   scrub_done,
  output logic                   done_patrol,
  output logic [1:0]             done_status,
  output logic                   err_flag,
  output logic [ADDR_W-1:0]      err_addr
);
  localparam int PAY_W = 8 * PAY_BYTES;
  localparam int CHK_W = 8 * CHK_BYTES;

  logic              p_pend, p_take, p_adv;
  logic [ADDR_W-1:0] p_addr;
  logic [PAY_W-1:0]  rd_data, fix_data;
  logic [CHK_W-1:0]  rd_chk, fix_chk;
  scrub_res_e        cls, status;

  assign done_status = status;

  scrub_patrol #(
    .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .INTERVAL(PATROL_INTERVAL)
  ) u_patrol (
    .clk(clk), .rst(rst), .take(p_take), .adv(p_adv), .pend(p_pend), .addr(p_addr)
  );

  scrub_code #(.PAY_W(PAY_W), .CHK_W(CHK_W)) u_code (
    .data(rd_data), .chk_in(rd_chk), .cls(cls), .fix_data(fix_data), .fix_chk(fix_chk)
  );

  scrub_seq #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .CHK_W(CHK_W)) u_seq (
    .clk(clk), .rst(rst),
    .dmd_req(dmd_req), .dmd_addr(dmd_addr), .dmd_ack(dmd_ack),
    .patrol_pend(p_pend), .patrol_addr(p_addr), .patrol_take(p_take), .patrol_adv(p_adv),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wcheck(mem_wcheck),
    .mem_gnt(mem_gnt), .mem_rsp(mem_rsp), .mem_rdata(mem_rdata), .mem_rcheck(mem_rcheck),
    .rd_data(rd_data), .rd_chk(rd_chk),
    .cls(cls), .fix_data(fix_data), .fix_chk(fix_chk),
    .busy(busy), .scrub_done(scrub_done), .done_patrol(done_patrol),
    .done_status(status), .err_flag(err_flag), .err_addr(err_addr)
  );
endmodule

// File: tb/tb_scrub_engine.sv
module tb_scrub_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int AW = 3;
  localparam int IV = 300;
  localparam int PW = 256;
  localparam int CW = 32;

  logic clk = 0, rst = 1;
  logic dmd_req = 0;
  logic [AW-1:0] dmd_addr = '0;
  logic dmd_ack, mem_req, mem_we, busy, scrub_done, done_patrol, err_flag;
  logic [AW-1:0] mem_addr, err_addr;
  logic [PW-1:0] mem_wdata, mem_rdata;
  logic [CW-1:0] mem_wcheck, mem_rcheck;
  logic mem_gnt, mem_rsp;
  logic [1:0] done_status;

  int checks = 0, errors = 0;
  int cyc = 0, lat = 0;
  logic [PW-1:0] mdata [NL];
  logic [CW-1:0] mchk [NL];
  int wr_cnt [NL];
  int rd_addr_log [64];
  int rd_cyc_log [64];
  int nrd = 0, pdone = 0, pbad = 0;

  scrub_engine #(.ADDR_W(AW), .NUM_LINES(NL), .PATROL_INTERVAL(IV)) dut (
    .clk(clk), .rst(rst), .dmd_req(dmd_req), .dmd_addr(dmd_addr), .dmd_ack(dmd_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wcheck(mem_wcheck), .mem_gnt(mem_gnt), .mem_rsp(mem_rsp), .mem_rdata(mem_rdata),
    .mem_rcheck(mem_rcheck), .busy(busy), .scrub_done(scrub_done), .done_patrol(done_patrol),
    .done_status(done_status), .err_flag(err_flag), .err_addr(err_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // R1 check word
  function automatic logic [CW-1:0] code_of(input logic [PW-1:0] d);
    logic [8:0] p = '0;
    logic q = 1'b0;
    for (int i = 0; i < PW; i++) if (d[i]) begin p ^= 9'(i + 1); q = ~q; end
    return {22'd0, q, p};
  endfunction

  // R2 expected outcome
  task automatic expect_of(input logic [PW-1:0] d, input logic [CW-1:0] c,
                           output logic [1:0] cls, output logic [PW-1:0] d2, output logic [CW-1:0] c2);
    logic [CW-1:0] s;
    s = code_of(d) ^ c;
    d2 = d; c2 = c;
    if (s == '0) cls = 2'b00;
    else if (s[31:10] == '0 && s[9] && s[8:0] >= 9'd1 && s[8:0] <= 9'd256) begin
      cls = 2'b01; d2[s[8:0] - 9'd1] = ~d2[s[8:0] - 9'd1]; c2 = code_of(d2);
    end else if ($countones(s) == 1) begin
      cls = 2'b01; c2 = code_of(d);
    end else cls = 2'b10;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: grants at once, responds after lat+1 cycles
  initial begin
    logic pendm = 0, m_we = 0;
    int wc = 0, ma = 0;
    mem_gnt = 0; mem_rsp = 0; mem_rdata = '0; mem_rcheck = '0;
    for (int i = 0; i < NL; i++) begin
      mdata[i] = {8{32'h5A3C_0F00 + 32'(i * 977)}} ^ (PW'(i) << (i * 29));
      mchk[i] = code_of(mdata[i]);
      wr_cnt[i] = 0;
    end
    forever begin
      @(negedge clk);
      cyc++;
      mem_gnt = 0; mem_rsp = 0;
      if (pendm) begin
        if (wc == 0) begin
          mem_rsp = 1; pendm = 0;
          if (!m_we) begin mem_rdata = mdata[ma]; mem_rcheck = mchk[ma]; end
        end else wc--;
      end else if (mem_req && !rst) begin
        mem_gnt = 1; pendm = 1; wc = lat; ma = int'(mem_addr); m_we = mem_we;
        if (mem_we) begin mdata[ma] = mem_wdata; mchk[ma] = mem_wcheck; wr_cnt[ma]++; end
        else if (nrd < 64) begin rd_addr_log[nrd] = ma; rd_cyc_log[nrd] = cyc; nrd++; end
      end
      if (scrub_done && done_patrol) begin
        pdone++;
        if (done_status != 2'b00) pbad++;
      end
    end
  end

  task automatic demand(input int a, input logic [PW-1:0] dflip, input logic [CW-1:0] cflip, input string tag);
    logic [PW-1:0] d0, dx; logic [CW-1:0] c0, cx; logic [1:0] cls; int w0;
    @(negedge clk);
    while (busy) @(negedge clk);
    mdata[a] ^= dflip; mchk[a] ^= cflip;
    d0 = mdata[a]; c0 = mchk[a]; w0 = wr_cnt[a];
    expect_of(d0, c0, cls, dx, cx);
    dmd_addr = AW'(a); dmd_req = 1;
    do @(negedge clk); while (!dmd_ack);
    dmd_req = 0;
    do @(negedge clk); while (!(scrub_done && !done_patrol));
    chk({tag, " status R2"}, 64'(done_status), 64'(cls));
    chk({tag, " data R3"}, 64'(mdata[a] == dx), 64'd1);
    chk({tag, " check R3"}, 64'(mchk[a]), 64'(cx));
    chk({tag, " writes R4"}, 64'(wr_cnt[a] - w0), (cls == 2'b01) ? 64'd1 : 64'd0);
    if (cls == 2'b10) begin
      chk({tag, " err_flag R5"}, 64'(err_flag), 64'd1);
      chk({tag, " err_addr R5"}, 64'(err_addr), 64'(a));
      mdata[a] ^= dflip; mchk[a] ^= cflip;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, t0, p0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", 64'(busy), 0); chk("R11 mem_req", 64'(mem_req), 0);
    chk("R11 err_flag", 64'(err_flag), 0); chk("R11 dmd_ack", 64'(dmd_ack), 0);
    chk("R11 scrub_done", 64'(scrub_done), 0);
    rst = 0;
    @(negedge clk);
    chk("R11 busy after", 64'(busy), 0);

    // R7 R9 patrol sweep over clean memory
    while (nrd < NL + 3) @(negedge clk);
    for (int i = 0; i < NL + 3; i++) chk("R9 patrol addr", 64'(rd_addr_log[i]), 64'(i % NL));
    for (int i = 0; i < NL + 2; i++) chk("R7 patrol gap", 64'(rd_cyc_log[i+1] - rd_cyc_log[i]), 64'(IV));
    chk("R4 no patrol writes", 64'(wr_cnt[0] + wr_cnt[3] + wr_cnt[7]), 0);
    chk("R12 patrol dones clean", 64'(pbad), 0);
    chk("R12 patrol done count", 64'(pdone >= NL + 2), 1);

    // R3 every single payload bit
    for (int b = 0; b < PW; b++) demand(b % NL, PW'(1) << b, '0, "R3 dbit");
    // R3 every single check bit, slower memory
    lat = 2;
    for (int b = 0; b < CW; b++) demand(b % NL, '0, CW'(1) << b, "R3 cbit");
    lat = 1;
    // R4 clean demand
    demand(5, '0, '0, "R4 clean");
    // R5 double faults
    for (int j = 0; j < 8; j++) demand(j, (PW'(1) << (j * 29)) | (PW'(1) << (j * 29 + 5)), '0, "R5 dbl");
    demand(2, PW'(1) << 7, CW'(1) << 20, "R5 mixed");
    demand(4, '0, '0, "R5 sticky");
    chk("R5 sticky flag", 64'(err_flag), 1);
    chk("R5 sticky addr", 64'(err_addr), 2);

    // R8 demand stream holds off patrol; held patrol runs at once afterwards
    lat = 0;
    @(negedge clk);
    while (busy) @(negedge clk);
    p0 = pdone; t0 = cyc; k = 0;
    dmd_addr = '0; dmd_req = 1;
    forever begin
      @(negedge clk);
      if (dmd_ack) begin
        k++;
        if (cyc - t0 >= IV + 40) begin dmd_req = 0; break; end
        dmd_addr = AW'(k % NL);
      end
    end
    chk("R8 no patrol during stream", 64'(pdone - p0), 0);
    chk("R6 demand count", 64'(k > 10), 1);
    do @(negedge clk); while (!scrub_done);
    chk("R6 last stream scrub is demand", 64'(done_patrol), 0);
    t0 = cyc;
    @(negedge clk);
    chk("R12 idle after done", 64'(busy), 0);
    do @(negedge clk); while (!scrub_done);
    chk("R8 held patrol next", 64'(done_patrol), 1);
    chk("R8 held patrol prompt", 64'(cyc - t0 < 20), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule